// File: doc/BRIEF.md
# Blocked Texture Cache Lookup and Tag Unit

This block is the address and tag side of an on-chip texture cache whose lines each hold a square 4×4 tile of 32-bit texels. A texel request arrives as a line base, integer texel coordinates (u, v) and a mip level. The block turns the request into a tile line address, looks it up in a 4-way set-associative tag store of 64 sets, and reports hit or miss, the set, the way and the texel position inside the line. The total capacity is 16 KB: 64 sets × 4 ways × 64-byte lines. Because the line address comes from the tile coordinates (u/4, v/4), every line covers a square footprint of the texture. Neighbouring texels of a filtered fragment therefore tend to fall in the same line.

On a miss, the block allocates a way at once, using invalid ways first and then a 3-bit tree pseudo-LRU. It queues a line-fill request for an abstract memory port that has a valid/ready handshake. Later lookups are not held back by fills that are still outstanding, so hits and further misses keep flowing until the miss queue could overflow. A flush input invalidates every line in one cycle. Two counters, one of accepted line fills and one of fragment strobes, let the texel-to-fragment ratio be derived.

Top module: `tc_tag_unit`

## Requirements
- R1: After reset, resp_valid, fill_valid, fill_count and frag_count are 0, req_ready is 1, and every line is invalid.
- R2: A request accepted on a clock edge (req_valid and req_ready) gives resp_valid high in the following cycle, with resp_offset = {v[1:0], u[1:0]}. Cycles with no accepted request give resp_valid low.
- R3: The line address is base + (level << 14) + ((v >> 2) << s) + (u >> 2), truncated to 24 bits, where s = 6 − level for levels below 6 and 0 otherwise. resp_set is bits [5:0] of that address, the tag is bits [23:6], and the fill request carries the full line address.
- R4: A lookup hits when its set holds a valid way with an equal tag. Any texel of a tile that has been looked up hits until that line is evicted or flushed.
- R5: A miss allocates the lowest-numbered invalid way of the set. If all four ways are valid, it uses the 3-bit tree: bit0 = 0 picks ways 0/1 and bit0 = 1 picks ways 2/3; bit1 picks between way 0 (0) and way 1 (1); bit2 picks between way 2 (0) and way 3 (1). Every hit or allocation of way w sets the bits on w's path to point away from w. The tree resets to 000 and a flush does not change it.
- R6: Up to 4 misses queue their fills without blocking later lookups. req_ready is low exactly when the queued fills plus a miss now being reported would reach 4.
- R7: fill_valid is high while any fill is queued. The front request (fill_line, fill_way) stays stable until fill_ready is seen, and fills leave in the order of their misses.
- R8: A flush invalidates all lines at the clock edge, so every following lookup misses until its line is allocated again.
- R9: fill_count rises by one for each fill handshake and frag_count rises by one for each cycle with frag_strobe high.
- R10: A hit reports the way that was allocated to that line by its miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Texel request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_base | input | 24 | Texture base, in lines |
| req_u | input | 12 | Texel column |
| req_v | input | 12 | Texel row |
| req_level | input | 4 | Mip level |
| flush | input | 1 | Invalidate all lines |
| frag_strobe | input | 1 | One fragment completed |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup hit |
| resp_set | output | 6 | Set index of the lookup |
| resp_way | output | 2 | Hit way, or way allocated on a miss |
| resp_offset | output | 4 | Texel index inside the line |
| fill_valid | output | 1 | Fill request pending |
| fill_ready | input | 1 | Memory port accepts the fill |
| fill_line | output | 24 | Line address to fetch |
| fill_way | output | 2 | Way receiving the line |
| fill_count | output | 32 | Accepted fills |
| frag_count | output | 32 | Fragments counted |

## Verification
The hardest state to reach is a full miss queue while hits to lines allocated but not yet filled keep arriving. The stimulus reaches it by holding fill_ready low through a run of distinct misses. It then mixes in lookups to tiles that were already allocated, and it also uses random stretches with back-pressure on the fill port. A second awkward case is pseudo-LRU eviction in a full set. Five lines that share one set are requested right after a flush, and then the first of them is requested again.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int PLRU_W = 3;

  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [PLRU_W-1:0] plru_t;

  function automatic way_t plru_victim(input plru_t p);
    way_t v;
    if (!p[0]) v = p[1] ? 2'd1 : 2'd0;
    else       v = p[2] ? 2'd3 : 2'd2;
    return v;
  endfunction

  function automatic plru_t plru_touch(input plru_t p, input way_t w);
    plru_t n;
    n    = p;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/tc_addr_gen.sv
module tc_addr_gen #(
  parameter int LINE_W    = 24,
  parameter int COORD_W   = 12,
  parameter int LEVEL_W   = 4,
  parameter int ROW_LOG2  = 6,
  parameter int MIP_SHIFT = 14
) (
  input  logic [LINE_W-1:0]  base,
  input  logic [COORD_W-1:0] u,
  input  logic [COORD_W-1:0] v,
  input  logic [LEVEL_W-1:0] level,
  output logic [LINE_W-1:0]  line,
  output logic [3:0]         offset
);
  localparam logic [LEVEL_W-1:0] ROW_L = LEVEL_W'(ROW_LOG2);

  logic [COORD_W-3:0] tile_u, tile_v;
  logic [LEVEL_W-1:0] shamt;
  logic [LINE_W-1:0]  row_term, mip_term;

  assign tile_u = u[COORD_W-1:2];
  assign tile_v = v[COORD_W-1:2];

  always_comb begin
    if (level >= ROW_L) shamt = '0;
    else                shamt = ROW_L - level;
    row_term = LINE_W'(tile_v) << shamt;
    mip_term = LINE_W'(level) << MIP_SHIFT;
    line     = base + mip_term + row_term + LINE_W'(tile_u);
    offset   = {v[1:0], u[1:0]};
  end
endmodule

// File: rtl/tc_tag_store.sv
module tc_tag_store
  import tc_pkg::*;
#(
  parameter int SETS_LOG2 = 6,
  parameter int TAG_W     = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 look_en,
  input  logic [SETS_LOG2-1:0] look_set,
  input  logic [TAG_W-1:0]     look_tag,
  output logic                 hit,
  output way_t                 alloc_way
);
  localparam int SETS = 1 << SETS_LOG2;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  plru_t            plru_q  [SETS];

  logic [WAYS-1:0] match;
  logic [WAYS-1:0] set_valid;
  way_t            hit_way, victim;
  logic            any_free;
  logic            install;
  plru_t           plru_nxt;

  assign set_valid = valid_q[look_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_valid[w] && (tag_q[look_set][w] == look_tag);
  end

  always_comb begin
    hit      = |match;
    hit_way  = '0;
    victim   = plru_victim(plru_q[look_set]);
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
      if (!set_valid[w]) begin
        victim   = WAY_W'(w);
        any_free = 1'b1;
      end
    end
    alloc_way = hit ? hit_way : victim;
    install   = look_en && !hit;
    plru_nxt  = plru_touch(plru_q[look_set], alloc_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else if (look_en) begin
      plru_q[look_set] <= plru_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (install) begin
      valid_q[look_set][alloc_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tag_q[look_set][alloc_way] <= look_tag;
  end

  logic unused_free;
  assign unused_free = any_free;
endmodule

// File: rtl/tc_miss_fifo.sv
module tc_miss_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 26,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int QC_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [QC_W-1:0] count
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [QC_W-1:0]  cnt_d;
  logic             do_pop;

  assign do_pop = pop && (count != '0);
  assign dout   = mem_q[rd_q];

  always_comb begin
    wr_d  = push   ? wr_q + PTR_W'(1) : wr_q;
    rd_d  = do_pop ? rd_q + PTR_W'(1) : rd_q;
    cnt_d = count + QC_W'(push) - QC_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end
endmodule

// File: rtl/tc_tag_unit.sv
module tc_tag_unit
  import tc_pkg::*;
#(
  parameter int LINE_W    = 24,
  parameter int COORD_W   = 12,
  parameter int LEVEL_W   = 4,
  parameter int SETS_LOG2 = 6,
  parameter int ROW_LOG2  = 6,
  parameter int MIP_SHIFT = 14,
  parameter int MQ_DEPTH  = 4,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LINE_W-1:0]    req_base,
  input  logic [COORD_W-1:0]   req_u,
  input  logic [COORD_W-1:0]   req_v,
  input  logic [LEVEL_W-1:0]   req_level,
  input  logic                 flush,
  input  logic                 frag_strobe,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [SETS_LOG2-1:0] resp_set,
  output logic [1:0]           resp_way,
  output logic [3:0]           resp_offset,
  output logic                 fill_valid,
  input  logic                 fill_ready,
  output logic [LINE_W-1:0]    fill_line,
  output logic [1:0]           fill_way,
  output logic [CNT_W-1:0]     fill_count,
  output logic [CNT_W-1:0]     frag_count
);
  localparam int TAG_W  = LINE_W - SETS_LOG2;
  localparam int ENT_W  = LINE_W + WAY_W;
  localparam int QC_W   = $clog2(MQ_DEPTH + 1);
  localparam logic [QC_W-1:0] QC_LIM = QC_W'(MQ_DEPTH);

  logic [LINE_W-1:0] new_line;
  logic [3:0]        new_off;
  logic              accept;
  logic              s1_valid_q, s1_valid_d;
  logic [LINE_W-1:0] s1_line_q, s1_line_d;
  logic [3:0]        s1_off_q, s1_off_d;
  logic              look_hit;
  way_t              look_way;
  logic              s1_miss;
  logic [QC_W-1:0]   q_count;
  logic [ENT_W-1:0]  q_head;
  logic              fill_fire;
  logic [CNT_W-1:0]  fill_cnt_d, frag_cnt_d;

  tc_addr_gen #(
    .LINE_W(LINE_W), .COORD_W(COORD_W), .LEVEL_W(LEVEL_W),
    .ROW_LOG2(ROW_LOG2), .MIP_SHIFT(MIP_SHIFT)
  ) u_addr (
    .base(req_base), .u(req_u), .v(req_v), .level(req_level),
    .line(new_line), .offset(new_off)
  );

  tc_tag_store #(.SETS_LOG2(SETS_LOG2), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_en(s1_valid_q),
    .look_set(s1_line_q[SETS_LOG2-1:0]),
    .look_tag(s1_line_q[LINE_W-1:SETS_LOG2]),
    .hit(look_hit), .alloc_way(look_way)
  );

  assign s1_miss = s1_valid_q && !look_hit;

  tc_miss_fifo #(.DEPTH(MQ_DEPTH), .W(ENT_W)) u_mq (
    .clk(clk), .rst_n(rst_n),
    .push(s1_miss), .din({s1_line_q, look_way}),
    .pop(fill_ready), .dout(q_head), .count(q_count)
  );

  assign req_ready = (q_count + QC_W'(s1_miss)) < QC_LIM;
  assign accept    = req_valid && req_ready;

  assign resp_valid  = s1_valid_q;
  assign resp_hit    = look_hit;
  assign resp_set    = s1_line_q[SETS_LOG2-1:0];
  assign resp_way    = look_way;
  assign resp_offset = s1_off_q;

  assign fill_valid = (q_count != '0);
  assign fill_line  = q_head[ENT_W-1:WAY_W];
  assign fill_way   = q_head[WAY_W-1:0];
  assign fill_fire  = fill_valid && fill_ready;

  always_comb begin
    s1_valid_d = accept;
    s1_line_d  = accept ? new_line : s1_line_q;
    s1_off_d   = accept ? new_off  : s1_off_q;
    fill_cnt_d = fill_fire   ? fill_count + CNT_W'(1) : fill_count;
    frag_cnt_d = frag_strobe ? frag_count + CNT_W'(1) : frag_count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_line_q  <= '0;
      s1_off_q   <= '0;
      fill_count <= '0;
      frag_count <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_line_q  <= s1_line_d;
      s1_off_q   <= s1_off_d;
      fill_count <= fill_cnt_d;
      frag_count <= frag_cnt_d;
    end
  end
endmodule

// File: rtl/tc_tag_unit_chk.sv
module tc_tag_unit_chk #(
  parameter int LINE_W   = 24,
  parameter int COORD_W  = 12,
  parameter int MQ_DEPTH = 4,
  parameter int CNT_W    = 32,
  parameter int QC_W     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [COORD_W-1:0] req_u,
  input logic [COORD_W-1:0] req_v,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic [3:0]         resp_offset,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic [LINE_W-1:0]  fill_line,
  input logic [1:0]         fill_way,
  input logic [CNT_W-1:0]   fill_count,
  input logic [QC_W-1:0]    q_count
);
  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid); // R2
  AST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_offset == {$past(req_v[1:0]), $past(req_u[1:0])}); // R2
  AST_MISS_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |=> fill_valid); // R6
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_line) && $stable(fill_way))); // R7
  AST_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> fill_count == $past(fill_count) + CNT_W'(1)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(MQ_DEPTH)); // R6
endmodule

bind tc_tag_unit tc_tag_unit_chk #(
  .LINE_W(LINE_W), .COORD_W(COORD_W), .MQ_DEPTH(MQ_DEPTH), .CNT_W(CNT_W), .QC_W(QC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_u(req_u), .req_v(req_v), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_offset(resp_offset), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_line(fill_line), .fill_way(fill_way), .fill_count(fill_count), .q_count(q_count)
);

// File: tb/tc_tag_unit_test.sv
module tc_tag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_base;
  logic [11:0] req_u, req_v;
  logic [3:0]  req_level;
  logic        flush, frag_strobe;
  logic        resp_valid, resp_hit;
  logic [5:0]  resp_set;
  logic [1:0]  resp_way;
  logic [3:0]  resp_offset;
  logic        fill_valid, fill_ready;
  logic [23:0] fill_line;
  logic [1:0]  fill_way;
  logic [31:0] fill_count, frag_count;

  always #4 clk = ~clk;

  tc_tag_unit uut (.*);

  int errors = 0;
  int checks = 0;

  logic [17:0] m_tag   [64][4];
  logic [3:0]  m_valid [64];
  logic [2:0]  m_plru  [64];
  logic [25:0] fq [$];
  int          fills_done = 0;
  int          frags_done = 0;

  logic        pend = 1'b0;
  logic [23:0] p_line;
  logic [3:0]  p_off;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_line(input logic [23:0] b, input logic [11:0] u,
                                           input logic [11:0] v, input logic [3:0] l);
    int sh;
    sh = (l >= 4'd6) ? 0 : 6 - int'(l);
    return b + (24'(l) << 14) + (24'(v >> 2) << sh) + 24'(u >> 2);
  endfunction

  task automatic step(input string lab, input bit rq, input logic [23:0] b,
                      input logic [11:0] u, input logic [11:0] v, input logic [3:0] l,
                      input bit frdy, input bit fl, input bit fr);
    logic [5:0]  s;
    logic [17:0] t;
    logic        h;
    logic [1:0]  w;
    logic [2:0]  p;
    @(negedge clk);
    chk("R9 fill_count", fill_count, fills_done);
    chk("R9 frag_count", frag_count, frags_done);
    chk("R7 fill_valid", fill_valid, fq.size() != 0);
    if (fill_valid && fq.size() != 0) begin
      chk("R3 fill_line", fill_line, fq[0][25:2]);
      chk("R7 fill_way", fill_way, fq[0][1:0]);
    end
    chk("R2 resp_valid", resp_valid, pend);
    if (pend) begin
      s = p_line[5:0];
      t = p_line[23:6];
      h = 1'b0;
      w = 2'd0;
      for (int i = 3; i >= 0; i--)
        if (m_valid[s][i] && m_tag[s][i] == t) begin h = 1'b1; w = 2'(i); end
      if (!h) begin
        p = m_plru[s];
        w = !p[0] ? (p[1] ? 2'd1 : 2'd0) : (p[2] ? 2'd3 : 2'd2);
        for (int i = 3; i >= 0; i--) if (!m_valid[s][i]) w = 2'(i);
      end
      chk({lab, " resp_hit"}, resp_hit, h);
      chk(h ? "R10 resp_way" : "R5 resp_way", resp_way, w);
      chk("R3 resp_set", resp_set, s);
      chk("R2 resp_offset", resp_offset, p_off);
      p = m_plru[s];
      p[0] = ~w[1];
      if (!w[1]) p[1] = ~w[0]; else p[2] = ~w[0];
      m_plru[s] = p;
      if (!h) begin
        m_valid[s][w] = 1'b1;
        m_tag[s][w]   = t;
        fq.push_back({p_line, w});
      end
    end
    chk("R6 req_ready", req_ready, fq.size() < 4);
    if (fill_valid && frdy && fq.size() != 0) begin
      void'(fq.pop_front());
      fills_done++;
    end
    if (fl) for (int i = 0; i < 64; i++) m_valid[i] = 4'b0;
    if (fr) frags_done++;
    pend        = rq && req_ready;
    p_line      = exp_line(b, u, v, l);
    p_off       = {v[1:0], u[1:0]};
    req_valid   = rq && req_ready;
    req_base    = b;
    req_u       = u;
    req_v       = v;
    req_level   = l;
    fill_ready  = frdy;
    flush       = fl;
    frag_strobe = fr;
  endtask

  task automatic idle(input int n, input bit frdy);
    for (int i = 0; i < n; i++) step("R4", 1'b0, 24'h0, 12'h0, 12'h0, 4'h0, frdy, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin m_valid[i] = 4'b0; m_plru[i] = 3'b0; end
    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_u = '0; req_v = '0;
    req_level = '0; flush = 1'b0; frag_strobe = 1'b0; fill_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 fill_valid", fill_valid, 0);
    chk("R1 fill_count", fill_count, 0);
    chk("R1 frag_count", frag_count, 0);

    // R3/R4: miss, then other texels of the same tile hit, then a mip level
    step("R4", 1, 24'h000100, 12'd5, 12'd9, 4'd0, 0, 0, 1);
    step("R4", 1, 24'h000100, 12'd6, 12'd10, 4'd0, 0, 0, 0);
    step("R4", 1, 24'h000100, 12'd7, 12'd11, 4'd0, 0, 0, 1);
    step("R3", 1, 24'h000100, 12'd37, 12'd90, 4'd2, 0, 0, 0);
    // R6: new miss with fills stalled, then a hit that is not held back
    step("R6", 1, 24'h004000, 12'd0, 12'd0, 4'd0, 0, 0, 0);
    step("R6", 1, 24'h000100, 12'd4, 12'd8, 4'd0, 0, 0, 0);
    idle(6, 1);
    // R8: flush then the same tile misses again
    step("R8", 0, 24'h0, 12'd0, 12'd0, 4'd0, 1, 1, 0);
    step("R8", 1, 24'h000100, 12'd5, 12'd9, 4'd0, 1, 0, 0);
    idle(4, 1);
    // R5: five lines in one set after a flush, then the first again
    step("R5", 0, 24'h0, 12'd0, 12'd0, 4'd0, 1, 1, 0);
    for (int k = 0; k < 5; k++) step("R5", 1, 24'h002000 + 24'(k * 64), 0, 0, 0, 1, 0, 0);
    step("R5", 1, 24'h002000, 0, 0, 0, 1, 0, 0);
    step("R10", 1, 24'h002040, 0, 0, 0, 1, 0, 0);
    idle(6, 1);
    // R6: fill port stalled while distinct misses arrive
    for (int k = 0; k < 7; k++) step("R6", 1, 24'h030000 + 24'(k * 3), 0, 0, 0, 0, 0, 0);
    step("R6", 1, 24'h030000, 0, 0, 0, 0, 0, 0);
    idle(8, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] b;
      int sel;
      sel = $urandom_range(0, 2);
      b = (sel == 0) ? 24'h0 : (sel == 1) ? 24'h001000 : 24'h023450;
      step("R4", ($urandom_range(0, 9) < 8), b, 12'($urandom_range(0, 31)),
           12'($urandom_range(0, 31)), 4'($urandom_range(0, 7)),
           ($urandom_range(0, 9) < 6), ($urandom_range(0, 299) == 0),
           ($urandom_range(0, 3) == 0));
    end
    idle(12, 1);
    chk("R9 final fill_count", fill_count, fills_done);
    chk("R7 final fill_valid", fill_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule